// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block is the master side of a two-wire management link to an Ethernet PHY. It turns one request into one complete clause-22 style read or write frame. A request carries a 5-bit PHY address, a 5-bit register number, a direction flag and 16 bits of write data. The block drives the management clock `mdc`, the data line `mdo` and its output enable `mdo_en`. On reads it samples `mdi`. When the frame is over it returns the 16 read bits and gives a one-cycle `done` pulse.

Each bit period has two phases of `HALF_DIV` system clocks each. The first is a low phase, in which `mdc` is 0 and the outgoing bit is placed on `mdo`. The second is a high phase, in which `mdc` is 1 and `mdi` is captured on its last cycle. A read frame takes 64 bit periods: one undriven turnaround bit, 16 captured data bits and one trailing undriven clock. A write frame takes 65 bit periods: two driven turnaround bits, 16 data bits and one trailing undriven clock.

The sequencer has four states:

- **IDLE**: all lines are low.
- **LOW**: the low phase of a bit period.
- **HIGH**: the high phase of a bit period.
- **DONE**: all lines are low and `done` is high.

Its transitions are:

- **accept** (IDLE→LOW, on `req_valid`).
- **rise** (LOW→HIGH, at the end of the phase).
- **next_bit** (HIGH→LOW, at the end of the phase when the bit is not the last one).
- **finish** (HIGH→DONE, at the end of the phase of the last bit).
- **release** (DONE→IDLE, always).

Top module: `mgmt_frame_master`

## Requirements
- R1: Out of reset and whenever idle, `mdc`, `mdo`, `mdo_en`, `done` and `busy` are all 0.
- R2: Bit periods 0 to 31 are preamble, with `mdo`=1 and `mdo_en`=1.
- R3: Bit periods 32 and 33 carry the start pattern 0,1. Periods 34 and 35 carry the operation code: 1,0 for a read and 0,1 for a write. All four are driven.
- R4: Periods 36 to 40 carry the PHY address and periods 41 to 45 carry the register number. Both fields are driven MSB first.
- R5: A read frame continues as follows. Period 46 is undriven (`mdo_en`=0, `mdo`=0). Periods 47 to 62 are undriven, and in each of them `mdi` is captured on the last cycle of the high phase to form read data MSB first. Period 63 is an undriven final clock. The frame is 64 periods in all.
- R6: A write frame continues as follows. Periods 46 and 47 are a driven turnaround of 1,0. Periods 48 to 63 carry the write data, driven MSB first. Period 64 is an undriven final clock. The frame is 65 periods in all.
- R7: Every bit period is `HALF_DIV` cycles with `mdc`=0 followed by `HALF_DIV` cycles with `mdc`=1. `mdo` and `mdo_en` change only while `mdc` is low. The first low cycle follows the accepting edge.
- R8: A request is accepted only in IDLE. `req_valid` has no effect while `busy` is 1, and `busy` stays high from accept through the DONE cycle.
- R9: After the last high phase there is exactly one DONE cycle. In that cycle `done`=1 and `mdc`, `mdo` and `mdo_en` are 0. The block is idle on the following cycle.
- R10: `rd_data` changes only on the DONE cycle of a read frame, when it takes the captured word. It holds otherwise, including across write frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_phy | input | ADDR_W | PHY address |
| req_reg | input | ADDR_W | Register number |
| req_wdata | input | DATA_W | Data for a write frame |
| busy | output | 1 | Frame in progress (accept through DONE) |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Word captured by the last read frame |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Management data out |
| mdo_en | output | 1 | Output enable for the data pad |
| mdi | input | 1 | Management data in |

## Verification
The embedded assertions check several properties on every cycle:

- The line is quiet whenever the block is idle.
- `mdo` and `mdo_en` stay stable across a high phase.
- `mdi` is captured only in an undriven high phase.
- `done` lasts a single cycle with quiet lines, and no phase shorter than two cycles is possible.
- `rd_data` holds outside `done`.

The exact content of each frame can only be shown by the bench scenarios. That means the preamble length, the start and operation codes, MSB-first field order, turnaround shape and frame length. The same holds for reads of all-ones, all-zeros and mixed words, for a mid-frame request being dropped, and for read data surviving a write. These scenarios compare every cycle against a reference model and a behavioural PHY.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
    // One-hot so that mdc and done are each a single flop output.
    typedef enum logic [3:0] {
        ST_IDLE = 4'b0001,
        ST_LOW  = 4'b0010,
        ST_HIGH = 4'b0100,
        ST_DONE = 4'b1000
    } mgmt_state_e;
endpackage

// File: rtl/mgmt_phase_timer.sv
module mgmt_phase_timer #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase_end
);
    generate
        if (HALF_DIV <= 1) begin : g_single
            assign phase_end = run;
        end else begin : g_count
            localparam int CW = $clog2(HALF_DIV);
            localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (!run || phase_end) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end

            assign phase_end = run && (cnt == LAST);

            // R7
            phase_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
                phase_end |=> !phase_end);
        end
    endgenerate
endmodule

// File: rtl/mgmt_bit_source.sv
module mgmt_bit_source #(
    parameter int PRE_LEN = 32,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int IDX_W   = 7
) (
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] phy,
    input  logic [ADDR_W-1:0] regn,
    input  logic [DATA_W-1:0] wdata,
    output logic              drv_bit,
    output logic              drv_en,
    output logic              sample_slot,
    output logic              last_bit
);
    localparam logic [IDX_W-1:0] P_START  = IDX_W'(PRE_LEN);
    localparam logic [IDX_W-1:0] P_OP     = IDX_W'(PRE_LEN + 2);
    localparam logic [IDX_W-1:0] P_PHY    = IDX_W'(PRE_LEN + 4);
    localparam logic [IDX_W-1:0] P_REG    = IDX_W'(PRE_LEN + 4 + ADDR_W);
    localparam logic [IDX_W-1:0] P_TA     = IDX_W'(PRE_LEN + 4 + 2*ADDR_W);
    localparam logic [IDX_W-1:0] P_RD     = IDX_W'(PRE_LEN + 5 + 2*ADDR_W);
    localparam logic [IDX_W-1:0] P_RD_END = IDX_W'(PRE_LEN + 5 + 2*ADDR_W + DATA_W);
    localparam logic [IDX_W-1:0] P_WD     = IDX_W'(PRE_LEN + 6 + 2*ADDR_W);
    localparam logic [IDX_W-1:0] P_WD_END = IDX_W'(PRE_LEN + 6 + 2*ADDR_W + DATA_W);

    logic [ADDR_W-1:0] a_sh;
    logic [DATA_W-1:0] d_sh;

    always_comb begin
        drv_bit     = 1'b0;
        drv_en      = 1'b0;
        sample_slot = 1'b0;
        a_sh        = '0;
        d_sh        = '0;
        if (bit_idx < P_START) begin
            drv_bit = 1'b1;
            drv_en  = 1'b1;
        end else if (bit_idx < P_OP) begin
            drv_bit = (bit_idx != P_START);
            drv_en  = 1'b1;
        end else if (bit_idx < P_PHY) begin
            drv_bit = (bit_idx == P_OP) ? !is_write : is_write;
            drv_en  = 1'b1;
        end else if (bit_idx < P_REG) begin
            a_sh    = phy << (bit_idx - P_PHY);
            drv_bit = a_sh[ADDR_W-1];
            drv_en  = 1'b1;
        end else if (bit_idx < P_TA) begin
            a_sh    = regn << (bit_idx - P_REG);
            drv_bit = a_sh[ADDR_W-1];
            drv_en  = 1'b1;
        end else if (!is_write) begin
            sample_slot = (bit_idx >= P_RD) && (bit_idx < P_RD_END);
        end else if (bit_idx < P_WD) begin
            drv_bit = (bit_idx == P_TA);
            drv_en  = 1'b1;
        end else if (bit_idx < P_WD_END) begin
            d_sh    = wdata << (bit_idx - P_WD);
            drv_bit = d_sh[DATA_W-1];
            drv_en  = 1'b1;
        end
    end

    assign last_bit = is_write ? (bit_idx == P_WD_END) : (bit_idx == P_RD_END);
endmodule

// File: rtl/mgmt_capture.sv
module mgmt_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    input  logic              commit,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            rd_data <= '0;
        end else begin
            if (shift_en) begin
                shreg <= {shreg[DATA_W-2:0], din};
            end
            if (commit) begin
                rd_data <= shreg;
            end
        end
    end
endmodule

// File: rtl/mgmt_frame_master.sv
module mgmt_frame_master
    import mgmt_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int PRE_LEN  = 32,
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_phy,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdc,
    output logic              mdo,
    output logic              mdo_en,
    input  logic              mdi
);
    localparam int FRAME_BITS = PRE_LEN + 2*ADDR_W + DATA_W + 7;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    mgmt_state_e       state_q, state_d;
    logic [IDX_W-1:0]  bit_q;
    logic              wr_q;
    logic [ADDR_W-1:0] phy_q, reg_q;
    logic [DATA_W-1:0] wd_q;

    logic run, phase_end, drv_bit, drv_en, sample_slot, last_bit;
    logic sample_en, commit, accept;

    assign run    = (state_q == ST_LOW) || (state_q == ST_HIGH);
    assign accept = (state_q == ST_IDLE) && req_valid;

    mgmt_phase_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .phase_end (phase_end)
    );

    mgmt_bit_source #(
        .PRE_LEN (PRE_LEN),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .IDX_W   (IDX_W)
    ) u_bits (
        .bit_idx     (bit_q),
        .is_write    (wr_q),
        .phy         (phy_q),
        .regn        (reg_q),
        .wdata       (wd_q),
        .drv_bit     (drv_bit),
        .drv_en      (drv_en),
        .sample_slot (sample_slot),
        .last_bit    (last_bit)
    );

    assign sample_en = (state_q == ST_HIGH) && phase_end && sample_slot;
    assign commit    = (state_q == ST_HIGH) && phase_end && last_bit && !wr_q;

    mgmt_capture #(.DATA_W(DATA_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sample_en),
        .din      (mdi),
        .commit   (commit),
        .rd_data  (rd_data)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_LOW;                   // accept
            ST_LOW:  if (phase_end) state_d = ST_HIGH;                  // rise
            ST_HIGH: if (phase_end) state_d = last_bit ? ST_DONE        // finish
                                                       : ST_LOW;        // next_bit
            ST_DONE: state_d = ST_IDLE;                                 // release
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and frame context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            wr_q    <= 1'b0;
            phy_q   <= '0;
            reg_q   <= '0;
            wd_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                bit_q <= '0;
                wr_q  <= req_write;
                phy_q <= req_phy;
                reg_q <= req_reg;
                wd_q  <= req_wdata;
            end else if ((state_q == ST_HIGH) && phase_end && !last_bit) begin
                bit_q <= bit_q + IDX_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        busy   = (state_q != ST_IDLE);
        done   = (state_q == ST_DONE);
        mdc    = (state_q == ST_HIGH);
        mdo    = run && drv_bit;
        mdo_en = run && drv_en;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdo && !mdo_en && !done));

    // R7
    high_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdo) && $stable(mdo_en)));

    // R5
    sample_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> (mdc && !mdo_en));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mdc && !mdo && !mdo_en));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rd_data));
endmodule

// File: tb/mgmt_frame_master_test.sv
module mgmt_frame_master_test;
    localparam int HD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, mdc, mdo, mdo_en, mdi;
    logic [15:0] rd_data;

    always #2.5 clk = ~clk;

    mgmt_frame_master #(.HALF_DIV(HD)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data),
        .mdc(mdc), .mdo(mdo), .mdo_en(mdo_en), .mdi(mdi)
    );

    int total = 0;
    int bad = 0;
    bit running = 1'b0;
    bit fin = 1'b0;

    // Behavioural PHY: counts falling mdc edges, presents bit k of the frame.
    int          fall_cnt = 0;
    int          base = 0;
    int          k;
    bit          phy_rd = 1'b0;
    logic [15:0] phy_word = '0;
    always @(negedge mdc) fall_cnt = fall_cnt + 1;
    assign k   = fall_cnt - base;
    assign mdi = (phy_rd && k >= 47 && k <= 62) ? phy_word[62 - k] : 1'b1;

    // Reference model: one entry per expected clock cycle.
    typedef struct packed {
        logic        mdc;
        logic        mdo;
        logic        en;
        logic        dn;
        logic        bsy;
        logic        upd;
        logic [15:0] rv;
    } exp_t;
    exp_t  q[$];
    string tq[$];
    logic [15:0] exp_rd = '0;
    int busy_cnt = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push_ent(input logic c, input logic d, input logic e, input logic dn,
                            input logic b, input logic u, input logic [15:0] rv, input string tag);
        exp_t x;
        x.mdc = c; x.mdo = d; x.en = e; x.dn = dn; x.bsy = b; x.upd = u; x.rv = rv;
        q.push_back(x);
        tq.push_back(tag);
    endtask

    task automatic push_bit(input logic d, input logic e, input string tag);
        repeat (HD) push_ent(1'b0, d, e, 1'b0, 1'b1, 1'b0, 16'h0, tag);
        repeat (HD) push_ent(1'b1, d, e, 1'b0, 1'b1, 1'b0, 16'h0, tag);
    endtask

    task automatic push_frame(input bit w, input logic [4:0] pa, input logic [4:0] ra,
                              input logic [15:0] wd, input logic [15:0] rv);
        push_ent(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, "R8");
        for (int i = 0; i < 32; i++) push_bit(1'b1, 1'b1, "R2");
        push_bit(1'b0, 1'b1, "R3");
        push_bit(1'b1, 1'b1, "R3");
        push_bit(!w, 1'b1, "R3");
        push_bit(w, 1'b1, "R3");
        for (int i = 4; i >= 0; i--) push_bit(pa[i], 1'b1, "R4");
        for (int i = 4; i >= 0; i--) push_bit(ra[i], 1'b1, "R4");
        if (!w) begin
            for (int i = 0; i < 18; i++) push_bit(1'b0, 1'b0, "R5");
            push_ent(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, rv, "R9");
        end else begin
            push_bit(1'b1, 1'b1, "R6");
            push_bit(1'b0, 1'b1, "R6");
            for (int i = 15; i >= 0; i--) push_bit(wd[i], 1'b1, "R6");
            push_bit(1'b0, 1'b0, "R6");
            push_ent(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0, "R9");
        end
    endtask

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        exp_t  e;
        string tg;
        if (rst_n && running) begin
            if (q.size() > 0) begin
                e  = q.pop_front();
                tg = tq.pop_front();
            end else begin
                e  = '0;
                tg = "R1";
            end
            if (e.upd) exp_rd = e.rv;
            if (busy) busy_cnt++;
            chk(mdc === e.mdc, (tg == "R1") ? "R1" : "R7", 32'(mdc), 32'(e.mdc));
            chk(mdo === e.mdo, tg, 32'(mdo), 32'(e.mdo));
            chk(mdo_en === e.en, tg, 32'(mdo_en), 32'(e.en));
            chk(done === e.dn, "R9", 32'(done), 32'(e.dn));
            chk(busy === e.bsy, "R8", 32'(busy), 32'(e.bsy));
            chk(rd_data === exp_rd, "R10", 32'(rd_data), 32'(exp_rd));
        end
    end

    task automatic issue(input bit w, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input logic [15:0] rv);
        @(posedge clk); #1;
        base      = fall_cnt;
        phy_rd    = !w;
        phy_word  = rv;
        busy_cnt  = 0;
        push_frame(w, pa, ra, wd, rv);
        req_valid = 1'b1;
        req_write = w;
        req_phy   = pa;
        req_reg   = ra;
        req_wdata = wd;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(mdc === 1'b0 && mdo === 1'b0 && mdo_en === 1'b0, "R1", {mdc, mdo, mdo_en}, 0);
        chk(done === 1'b0 && busy === 1'b0 && rd_data === 16'h0, "R1", {done, busy, rd_data}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        running = 1'b1;
        repeat (4) @(posedge clk);

        // R5: mixed read word
        issue(1'b0, 5'h11, 5'h02, 16'h0, 16'hA5C3);
        wait_idle();
        chk(rd_data === 16'hA5C3, "R5", rd_data, 16'hA5C3);
        chk(busy_cnt == 64*2*HD + 1, "R5", busy_cnt, 64*2*HD + 1);

        // R6: write frame, R10 read data held across it
        issue(1'b1, 5'h1F, 5'h00, 16'h8001, 16'h0);
        wait_idle();
        chk(rd_data === 16'hA5C3, "R10", rd_data, 16'hA5C3);
        chk(busy_cnt == 65*2*HD + 1, "R6", busy_cnt, 65*2*HD + 1);

        // R4: boundary address values, all-ones read
        issue(1'b0, 5'h00, 5'h1F, 16'h0, 16'hFFFF);
        wait_idle();
        chk(rd_data === 16'hFFFF, "R5", rd_data, 16'hFFFF);

        // R8: request during a frame is dropped
        issue(1'b0, 5'h0A, 5'h15, 16'h0, 16'h3C96);
        repeat (100) @(posedge clk);
        #1;
        req_valid = 1'b1; req_write = 1'b1; req_phy = 5'h03; req_reg = 5'h07; req_wdata = 16'hFFFF;
        @(posedge clk); #1;
        req_valid = 1'b0;
        wait_idle();
        chk(busy_cnt == 64*2*HD + 1, "R8", busy_cnt, 64*2*HD + 1);
        chk(rd_data === 16'h3C96, "R8", rd_data, 16'h3C96);

        // R6: all-zero write data, R9 back-to-back start right after release
        issue(1'b1, 5'h15, 5'h0A, 16'h0000, 16'h0);
        wait_idle();
        issue(1'b0, 5'h01, 5'h10, 16'h0, 16'h0001);
        wait_idle();
        chk(rd_data === 16'h0001, "R5", rd_data, 16'h0001);

        repeat (5) @(posedge clk);
        if (!fin) begin
            fin = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!fin) begin
            fin = 1'b1;
            total++;
            bad++;
            $display("FAIL R1 watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule